// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block is the data path of a small accumulator-based controller. It keeps the 8-bit accumulator and an 8-bit status byte. On each clock edge where the strobe `op_valid` is high, it applies one of sixteen operations to the accumulator and the operand byte. The operations are load, increment, decrement, add, add with carry, subtract with borrow, OR, AND, XOR, four rotates, nibble swap, decimal adjust and compare. The new accumulator and status byte appear on the outputs in the cycle after the edge.

Each operation changes only the flags that belong to it. Add, add with carry and subtract with borrow write carry, auxiliary carry and overflow. Compare writes only carry. The rotates through carry and decimal adjust move only carry. Every other operation leaves the flags as they were. The parity bit always follows the accumulator. Software owns four status bits, which only the status-word write port can change. There is no plain subtract and there are no zero or negative flags.

Top module: `byte_alu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator and every status bit are cleared to 0x00.
- R2: An operation takes effect only on an edge where `op_valid` is 1, and its result is visible on the outputs after that edge. Load (op 0) copies `operand` into the accumulator.
- R3: Add (op 3) and add with carry (op 4) add the operand to the accumulator; op 4 also adds the carry. Carry is set to the carry out of bit 7, auxiliary carry to the carry out of bit 3, and overflow to signed overflow. Op 3 ignores the incoming carry.
- R4: Subtract with borrow (op 5) always subtracts the operand plus the carry. Carry is set to the borrow out of bit 7 and auxiliary carry to the borrow into bit 3. Overflow is set when the two operands differ in sign and the result's sign differs from the accumulator's old sign.
- R5: The following operations leave carry, auxiliary carry and overflow unchanged: load (0), increment (1), decrement (2), OR (6), AND (7), XOR (8), rotate right (9), rotate left (10) and swap (13).
- R6: Rotate right (9) and rotate left (10) rotate the 8 accumulator bits. Rotate right through carry (11) shifts carry into bit 7 and bit 0 into carry. Rotate left through carry (12) shifts carry into bit 0 and bit 7 into carry.
- R7: Swap (13) exchanges the upper and lower 4-bit halves of the accumulator.
- R8: Decimal adjust (14) first adds 0x06 if the low nibble is above 9 or auxiliary carry is 1. It then adds 0x60 if the resulting high nibble is above 9 or carry is 1. A carry out of either addition sets carry; carry is never cleared.
- R9: Compare (op 15) sets carry to the borrow of accumulator minus operand, with no carry in. It leaves the accumulator, auxiliary carry and overflow unchanged.
- R10: Status bit 0 equals the XOR of the eight accumulator bits in every cycle; writes to bit 0 are ignored.
- R11: The status byte is {carry[7], aux carry[6], user flag A[5], bank high[4], bank low[3], overflow[2], user flag B[1], parity[0]}. When `psw_wr` is 1, bits 7 to 1 load from `psw_wdata`. Bits 5, 4, 3 and 1 change only through this write.
- R12: When `psw_wr` and `op_valid` are both 1 on the same edge, the operation's value wins for every flag the operation updates. The written value applies to all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Applies `op_code` on this edge |
| op_code | input | 4 | Operation select (0 to 15) |
| operand | input | 8 | Second operand byte |
| psw_wr | input | 1 | Status-word write strobe |
| psw_wdata | input | 8 | Status-word write data |
| acc_out | output | 8 | Accumulator |
| psw_out | output | 8 | Status byte |

## Verification
The assertions check several properties on every cycle. Parity tracks the accumulator. Software-owned status bits hold without a write. Operations that must not move the arithmetic flags leave them intact. Compare never alters the accumulator, and its carry matches an unsigned less-than of the previous values. Decimal adjust never drops a set carry. Arithmetic values can only be shown by the directed scenarios. These include the exact sums, borrows, nibble carries and signed overflow cases, the two-step decimal correction, the rotates through carry, and the priority between a status write and an operation on the same edge.

// File: rtl/alu_pkg.sv
// Shared constants and types for the byte arithmetic unit.
// Assumes an 8-bit data path made of two 4-bit digits.
package alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    // Status byte bit positions; software and neighbours decode these.
    localparam int PSW_CY  = 7;
    localparam int PSW_AC  = 6;
    localparam int PSW_UA  = 5;
    localparam int PSW_BK1 = 4;
    localparam int PSW_BK0 = 3;
    localparam int PSW_OV  = 2;
    localparam int PSW_UB  = 1;
    localparam int PSW_PAR = 0;

    typedef enum logic [3:0] {
        OP_LOAD = 4'd0,  OP_INC  = 4'd1,  OP_DEC  = 4'd2,  OP_ADD  = 4'd3,
        OP_ADDC = 4'd4,  OP_SUBB = 4'd5,  OP_OR   = 4'd6,  OP_AND  = 4'd7,
        OP_XOR  = 4'd8,  OP_RR   = 4'd9,  OP_RL   = 4'd10, OP_RRC  = 4'd11,
        OP_RLC  = 4'd12, OP_SWAP = 4'd13, OP_DA   = 4'd14, OP_CMP  = 4'd15
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared adder for add, add with carry, subtract with borrow and compare.
// Subtraction uses the inverted operand and inverted carry-in; the carry
// outputs are inverted back so they read as borrows. Purely combinational.
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cy_out,
    output logic         ac_out,
    output logic         ov_out
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   full;
    logic [N:0]   low;

    // Form the effective operand and carry-in for add or subtract.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = cin ^ sub;
    end

    // Full-width and low-digit sums; carries flipped to borrows on subtract.
    always_comb begin
        full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low    = {1'b0, a[N-1:0]} + {1'b0, b_eff[N-1:0]} + {{N{1'b0}}, c_eff};
        res    = full[W-1:0];
        cy_out = full[W] ^ sub;
        ac_out = low[N] ^ sub;
        ov_out = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_bitops.sv
// Logical operations, rotates and nibble swap on the accumulator.
// Assumes the caller selects this result only for those operation codes.
module alu_bitops
    import alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cy_in,
    output logic [W-1:0] res,
    output logic         cy_out
);
    // Select the bitwise or rotate result and the carry it produces.
    always_comb begin
        res    = a;
        cy_out = cy_in;
        case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_RR:   res = {a[0], a[W-1:1]};
            OP_RL:   res = {a[W-2:0], a[W-1]};
            OP_RRC:  begin res = {cy_in, a[W-1:1]}; cy_out = a[0];   end
            OP_RLC:  begin res = {a[W-2:0], cy_in}; cy_out = a[W-1]; end
            OP_SWAP: res = {a[N-1:0], a[W-1:N]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu_decadj.sv
// Decimal correction of the accumulator after a packed-BCD addition.
// Two chained conditional adds: low digit first, then high digit.
// Carry may be set by either step but is never cleared.
module alu_decadj
    import alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic         cy_in,
    input  logic         ac_in,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam logic [N-1:0] DIGIT_MAX = N'(9);
    localparam logic [W:0]   FIX_LO    = (W+1)'(6);
    localparam logic [W:0]   FIX_HI    = (W+1)'(6) << N;

    logic       fix_lo, fix_hi, c_mid;
    logic [W:0] step1, step2;

    // Low-digit correction and its carry.
    always_comb begin
        fix_lo = (a[N-1:0] > DIGIT_MAX) || ac_in;
        step1  = {1'b0, a} + (fix_lo ? FIX_LO : '0);
        c_mid  = cy_in | step1[W];
    end

    // High-digit correction on the partly corrected value.
    always_comb begin
        fix_hi = (step1[W-1:N] > DIGIT_MAX) || c_mid;
        step2  = {1'b0, step1[W-1:0]} + (fix_hi ? FIX_HI : '0);
        res    = step2[W-1:0];
        cy_out = c_mid | step2[W];
    end
endmodule

// File: rtl/alu_status.sv
// Status byte register: arithmetic flags, software-owned bits and parity.
// Assumes the write port is applied first; flag updates from the current
// operation then override it. Parity is registered from the next accumulator.
module alu_status
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         upd_cy,
    input  logic         new_cy,
    input  logic         upd_acov,
    input  logic         new_ac,
    input  logic         new_ov,
    input  logic [W-1:0] acc_nxt,
    output logic [W-1:0] psw
);
    logic cy_q, ac_q, ua_q, bk1_q, bk0_q, ov_q, ub_q, par_q;

    // Update each status bit: reset, write port, then operation flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cy_q  <= 1'b0; ac_q  <= 1'b0; ua_q <= 1'b0; bk1_q <= 1'b0;
            bk0_q <= 1'b0; ov_q  <= 1'b0; ub_q <= 1'b0; par_q <= 1'b0;
        end else begin
            if (wr_en) begin
                cy_q  <= wr_data[PSW_CY];
                ac_q  <= wr_data[PSW_AC];
                ua_q  <= wr_data[PSW_UA];
                bk1_q <= wr_data[PSW_BK1];
                bk0_q <= wr_data[PSW_BK0];
                ov_q  <= wr_data[PSW_OV];
                ub_q  <= wr_data[PSW_UB];
            end
            if (upd_cy) begin
                cy_q <= new_cy;
            end
            if (upd_acov) begin
                ac_q <= new_ac;
                ov_q <= new_ov;
            end
            par_q <= ^acc_nxt;
        end
    end

    // Assemble the status byte in its fixed bit order.
    always_comb begin
        psw          = '0;
        psw[PSW_CY]  = cy_q;
        psw[PSW_AC]  = ac_q;
        psw[PSW_UA]  = ua_q;
        psw[PSW_BK1] = bk1_q;
        psw[PSW_BK0] = bk0_q;
        psw[PSW_OV]  = ov_q;
        psw[PSW_UB]  = ub_q;
        psw[PSW_PAR] = par_q;
    end

    // R11: software-owned bits hold unless the write port is used.
    p_sw_bits_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({ua_q, bk1_q, bk0_q, ub_q}));
endmodule

// File: rtl/byte_alu_core.sv
// Accumulator and status byte of a small controller's arithmetic unit.
// One operation per strobed edge; the operand arrives directly on a port.
// Assumes op_code is valid whenever op_valid is high (all 16 codes defined).
module byte_alu_core
    import alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] operand,
    input  logic         psw_wr,
    input  logic [W-1:0] psw_wdata,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] psw_out
);
    alu_op_e      op;
    logic [W-1:0] acc_q, acc_nxt;
    logic         as_cin, as_sub, as_cy, as_ac, as_ov;
    logic [W-1:0] as_res, bo_res, da_res;
    logic         bo_cy, da_cy;
    logic         upd_cy, new_cy, upd_acov;
    logic         cy_now, ac_now;

    assign op     = alu_op_e'(op_code);
    assign cy_now = psw_out[PSW_CY];
    assign ac_now = psw_out[PSW_AC];

    // Configure the shared adder: carry-in only for the chained forms.
    always_comb begin
        as_sub = (op == OP_SUBB) || (op == OP_CMP);
        as_cin = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_now : 1'b0;
    end

    alu_addsub #(.W(W), .N(N)) i_addsub (
        .a(acc_q), .b(operand), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cy_out(as_cy), .ac_out(as_ac), .ov_out(as_ov)
    );

    alu_bitops #(.W(W), .N(N)) i_bitops (
        .op(op), .a(acc_q), .b(operand), .cy_in(cy_now),
        .res(bo_res), .cy_out(bo_cy)
    );

    alu_decadj #(.W(W), .N(N)) i_decadj (
        .a(acc_q), .cy_in(cy_now), .ac_in(ac_now),
        .res(da_res), .cy_out(da_cy)
    );

    // Choose the next accumulator and which flags the operation owns.
    always_comb begin
        acc_nxt  = acc_q;
        upd_cy   = 1'b0;
        upd_acov = 1'b0;
        new_cy   = cy_now;
        if (op_valid) begin
            case (op)
                OP_LOAD: acc_nxt = operand;
                OP_INC:  acc_nxt = acc_q + W'(1);
                OP_DEC:  acc_nxt = acc_q - W'(1);
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    acc_nxt  = as_res;
                    upd_cy   = 1'b1;
                    upd_acov = 1'b1;
                    new_cy   = as_cy;
                end
                OP_CMP: begin
                    upd_cy = 1'b1;
                    new_cy = as_cy;
                end
                OP_DA: begin
                    acc_nxt = da_res;
                    upd_cy  = 1'b1;
                    new_cy  = da_cy;
                end
                OP_RRC, OP_RLC: begin
                    acc_nxt = bo_res;
                    upd_cy  = 1'b1;
                    new_cy  = bo_cy;
                end
                default: acc_nxt = bo_res;
            endcase
        end
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

    alu_status #(.W(W)) i_status (
        .clk(clk), .rst_n(rst_n), .wr_en(psw_wr), .wr_data(psw_wdata),
        .upd_cy(upd_cy), .new_cy(new_cy), .upd_acov(upd_acov),
        .new_ac(as_ac), .new_ov(as_ov), .acc_nxt(acc_nxt), .psw(psw_out)
    );

    assign acc_out = acc_q;

    // R10: parity bit follows the accumulator in every cycle.
    p_parity_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        psw_out[PSW_PAR] == ^acc_out);

    // R2: without the strobe the accumulator holds.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc_out));

    // R5: non-arithmetic operations keep carry, aux carry and overflow.
    p_flags_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !psw_wr && (op inside {OP_LOAD, OP_INC, OP_DEC, OP_OR,
            OP_AND, OP_XOR, OP_RR, OP_RL, OP_SWAP}))
        |=> ($stable(psw_out[PSW_CY]) && $stable(psw_out[PSW_AC])
             && $stable(psw_out[PSW_OV])));

    // R9: compare leaves the accumulator untouched.
    p_cmp_keeps_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CMP) |=> $stable(acc_out));

    // R9: compare carry is an unsigned less-than of the prior values.
    p_cmp_borrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CMP)
        |=> (psw_out[PSW_CY] == ($past(acc_out) < $past(operand))));

    // R8: decimal adjust never clears a carry that was set.
    p_da_carry_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_DA && psw_out[PSW_CY]) |=> psw_out[PSW_CY]);
endmodule

// File: tb/test_byte_alu_core.sv
// Directed bench: one task per scenario, each checks its own results.
module test_byte_alu_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [3:0] op_code;
    logic [7:0] operand;
    logic       psw_wr;
    logic [7:0] psw_wdata;
    logic [7:0] acc_out;
    logic [7:0] psw_out;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [3:0] LOAD = 4'd0,  INC  = 4'd1,  DEC  = 4'd2,  ADD  = 4'd3,
                           ADDC = 4'd4,  SUBB = 4'd5,  ORL  = 4'd6,  ANL  = 4'd7,
                           XRL  = 4'd8,  RR   = 4'd9,  RL   = 4'd10, RRC  = 4'd11,
                           RLC  = 4'd12, SWP  = 4'd13, DAA  = 4'd14, CMP  = 4'd15;

    byte_alu_core i_byte_alu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
        .acc_out(acc_out), .psw_out(psw_out)
    );

    always #5 clk = ~clk;

    // Compare one byte and report a miscompare.
    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Drive one edge of stimulus from a falling edge; outputs settle after it.
    task automatic cycle(input logic v, input logic [3:0] o, input logic [7:0] d,
                         input logic w, input logic [7:0] wd);
        op_valid = v; op_code = o; operand = d; psw_wr = w; psw_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0; psw_wr = 1'b0;
    endtask

    task automatic do_op(input logic [3:0] o, input logic [7:0] d);
        cycle(1'b1, o, d, 1'b0, 8'h00);
    endtask

    task automatic wr_psw(input logic [7:0] wd);
        cycle(1'b0, LOAD, 8'h00, 1'b1, wd);
    endtask

    task automatic t_reset;
        check("R1", "acc after reset", acc_out, 8'h00);
        check("R1", "psw after reset", psw_out, 8'h00);
    endtask

    task automatic t_load_strobe;
        do_op(LOAD, 8'h3C);
        check("R2", "load acc", acc_out, 8'h3C);
        cycle(1'b0, LOAD, 8'h55, 1'b0, 8'h00);
        check("R2", "no strobe keeps acc", acc_out, 8'h3C);
    endtask

    task automatic t_add;
        do_op(ADD, 8'hC4);
        check("R3", "add wrap acc", acc_out, 8'h00);
        check("R3", "add wrap psw", psw_out, 8'hC0);
        do_op(LOAD, 8'h7F);
        do_op(ADD, 8'h01);
        check("R3", "signed ovf acc", acc_out, 8'h80);
        check("R3", "signed ovf psw", psw_out, 8'h45);
        wr_psw(8'h80);
        do_op(LOAD, 8'h10);
        do_op(ADDC, 8'h20);
        check("R3", "addc acc", acc_out, 8'h31);
        check("R3", "addc psw", psw_out, 8'h01);
        wr_psw(8'h80);
        do_op(LOAD, 8'h10);
        do_op(ADD, 8'h20);
        check("R3", "add ignores carry", acc_out, 8'h30);
        check("R3", "add ignores carry psw", psw_out, 8'h00);
    endtask

    task automatic t_subb;
        wr_psw(8'h80);
        do_op(LOAD, 8'h50);
        do_op(SUBB, 8'h20);
        check("R4", "subb with borrow in", acc_out, 8'h2F);
        check("R4", "subb nibble borrow psw", psw_out, 8'h41);
        do_op(LOAD, 8'h80);
        do_op(SUBB, 8'h01);
        check("R4", "subb ovf acc", acc_out, 8'h7F);
        check("R4", "subb ovf psw", psw_out, 8'h45);
        do_op(LOAD, 8'h00);
        do_op(SUBB, 8'h01);
        check("R4", "subb borrow acc", acc_out, 8'hFF);
        check("R4", "subb borrow psw", psw_out, 8'hC0);
    endtask

    task automatic t_incdec_logic;
        wr_psw(8'hC4);
        do_op(LOAD, 8'hFF);
        do_op(INC, 8'h00);
        check("R5", "inc wrap acc", acc_out, 8'h00);
        check("R5", "inc keeps flags", psw_out, 8'hC4);
        do_op(DEC, 8'h00);
        check("R5", "dec wrap acc", acc_out, 8'hFF);
        check("R5", "dec keeps flags", psw_out, 8'hC4);
        do_op(LOAD, 8'hF0);
        do_op(ORL, 8'h0F);
        check("R5", "or acc", acc_out, 8'hFF);
        do_op(ANL, 8'h3C);
        check("R5", "and acc", acc_out, 8'h3C);
        do_op(XRL, 8'hFF);
        check("R5", "xor acc", acc_out, 8'hC3);
        check("R5", "logic keeps flags", psw_out, 8'hC4);
    endtask

    task automatic t_rotate_swap;
        wr_psw(8'h04);
        do_op(LOAD, 8'h81);
        do_op(RR, 8'h00);
        check("R6", "rotate right", acc_out, 8'hC0);
        do_op(RL, 8'h00);
        check("R6", "rotate left", acc_out, 8'h81);
        check("R5", "rotates keep flags", psw_out, 8'h04);
        do_op(RRC, 8'h00);
        check("R6", "rrc acc", acc_out, 8'h40);
        check("R6", "rrc psw", psw_out, 8'h85);
        do_op(RLC, 8'h00);
        check("R6", "rlc acc", acc_out, 8'h81);
        check("R6", "rlc psw", psw_out, 8'h04);
        do_op(LOAD, 8'hA5);
        do_op(SWP, 8'h00);
        check("R7", "swap acc", acc_out, 8'h5A);
        check("R7", "swap psw", psw_out, 8'h04);
    endtask

    task automatic t_decadj;
        wr_psw(8'h00);
        do_op(LOAD, 8'h38);
        do_op(ADD, 8'h45);
        do_op(DAA, 8'h00);
        check("R8", "bcd 38+45 acc", acc_out, 8'h83);
        check("R8", "bcd 38+45 psw", psw_out, 8'h01);
        do_op(LOAD, 8'h99);
        do_op(ADD, 8'h99);
        check("R3", "99+99 psw", psw_out, 8'hC5);
        do_op(DAA, 8'h00);
        check("R8", "bcd 99+99 acc", acc_out, 8'h98);
        check("R8", "bcd 99+99 psw", psw_out, 8'hC5);
        wr_psw(8'h80);
        do_op(LOAD, 8'h12);
        do_op(DAA, 8'h00);
        check("R8", "carry forces high fix", acc_out, 8'h72);
        check("R8", "carry kept", psw_out, 8'h80);
    endtask

    task automatic t_compare;
        wr_psw(8'h44);
        do_op(LOAD, 8'h40);
        do_op(CMP, 8'h41);
        check("R9", "cmp less acc", acc_out, 8'h40);
        check("R9", "cmp less psw", psw_out, 8'hC5);
        do_op(CMP, 8'h40);
        check("R9", "cmp equal psw", psw_out, 8'h45);
        wr_psw(8'hC4);
        do_op(CMP, 8'h10);
        check("R9", "cmp no carry in psw", psw_out, 8'h45);
        check("R9", "cmp keeps acc", acc_out, 8'h40);
    endtask

    task automatic t_psw_port;
        wr_psw(8'hFF);
        check("R11", "write all ones", psw_out, 8'hFF);
        do_op(LOAD, 8'h03);
        wr_psw(8'h01);
        check("R10", "parity bit not writable", psw_out, 8'h00);
        wr_psw(8'h3A);
        check("R11", "sw bits written", psw_out, 8'h3A);
        do_op(ADD, 8'h01);
        check("R11", "add keeps sw bits", psw_out, 8'h3B);
        check("R10", "parity after add", {7'h00, psw_out[0]}, 8'h01);
    endtask

    task automatic t_same_edge;
        do_op(LOAD, 8'h01);
        cycle(1'b1, ADD, 8'hFF, 1'b1, 8'h00);
        check("R12", "op flags win acc", acc_out, 8'h00);
        check("R12", "op flags win psw", psw_out, 8'hC0);
        cycle(1'b1, INC, 8'h00, 1'b1, 8'hFE);
        check("R12", "write wins for unowned flags", psw_out, 8'hFF);
        check("R12", "inc with write acc", acc_out, 8'h01);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; operand = 8'h00;
        psw_wr = 1'b0; psw_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_strobe();
        t_add();
        t_subb();
        t_incdec_logic();
        t_rotate_swap();
        t_decadj();
        t_compare();
        t_psw_port();
        t_same_edge();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule